// File: doc/BRIEF.md
# Microwire Half-Duplex Serial Master

This block is the master side of a half-duplex serial link that uses the Microwire frame format. A host places 8-bit commands in a transmit queue. For each command the block opens a frame by pulling the active-low select line low. It shifts the command out most significant bit first and leaves one idle serial period for turnaround while the slave decodes the command. It then clocks in a response word. The response length is programmable from 4 to 16 bits, so a frame lasts 13 to 25 serial clock periods.

When the select line returns high, the response is placed right-justified and zero-extended in a 16-bit receive queue that the host drains with a valid/ready handshake. If that queue is full, the word is dropped and a sticky overrun flag is raised. The serial clock period is a parameter given in system clocks. The data output has a separate enable, so the pad can be put in high impedance whenever the master is not driving a command.

Top module: `mw_master`

## Requirements
- R1: After reset and between frames the select line `fs_n` is high, `sclk` is low, `sdo_oe` is low, `rx_valid` is low, `ovr` is low and `tx_ready` is high.
- R2: A command waiting in the transmit queue starts a frame. `fs_n` stays low for the whole frame, and the frame contains exactly 9+L rising edges of `sclk`, where L is the effective response length.
- R3: The 8 command bits appear on `sdo` MSB first. `sdo_oe` is high during them. `sdo` changes only while `sclk` is low and is stable at each rising edge.
- R4: The serial period after the last command bit is a turnaround: `sdo_oe` is low and `sdi` is not captured. `sdi` is also ignored during the command bits.
- R5: The L response bits are sampled from `sdi` on rising `sclk` edges, MSB first, and form a 16-bit word with the last bit in bit 0 and the upper 16-L bits zero. `sdo_oe` stays low during them.
- R6: `resp_len` (5 bits) gives L. Values below 4 act as 4, and values above 16 act as 16. The value is captured at frame start, so changes during a frame have no effect on that frame.
- R7: Between two frames `fs_n` stays high for at least one serial period (2*HALF_DIV system clocks).
- R8: The response word is written to the receive queue when `fs_n` returns high. It is visible on `rx_valid`/`rx_data` within 3 system clocks, and responses leave the queue in frame order.
- R9: A response that finds the receive queue full is discarded and sets `ovr`, which stays set until reset. The words already queued are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Command offered to the transmit queue |
| tx_data | input | 8 | Command byte |
| tx_ready | output | 1 | Transmit queue has room |
| resp_len | input | 5 | Response length in bits (effective 4..16) |
| rx_valid | output | 1 | A response word is available |
| rx_data | output | 16 | Oldest response word, right-justified |
| rx_ready | input | 1 | Host takes the current response word |
| ovr | output | 1 | Sticky receive overrun flag |
| sclk | output | 1 | Serial clock, idles low |
| fs_n | output | 1 | Active-low frame select |
| sdo | output | 1 | Serial command data |
| sdo_oe | output | 1 | Output enable for `sdo` (low means high impedance) |
| sdi | input | 1 | Serial response data |

## Verification
The bench holds `sdi` high during the command and the turnaround. A design that sampled too early, or counted the turnaround as a response bit, would leak ones into the upper bits of the word or shift the response by one place. The shortest (4) and longest (16) response lengths are exercised, along with out-of-range `resp_len` values and a length change in the middle of a frame. A wrong clamp or an unlatched length shows up as a wrong count of clock edges per frame. Back-to-back commands test the minimum select-high gap. Five frames into a four-entry receive queue check that the fifth word is dropped, that the first four survive in order, and that the overrun flag neither fires early nor clears itself.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int CMD_BITS  = 8;
    localparam int RESP_MIN  = 4;
    localparam int RESP_MAX  = 16;
    localparam int LEN_W     = 5;
    localparam int TURN_BITS = 1;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FRAME = 2'd1,
        PH_GAP   = 2'd2
    } mw_phase_e;
endpackage

// File: rtl/mw_fifo.sv
module mw_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_q, s_d;
    logic [W-1:0] mem_q [DEPTH];
    logic do_wr, do_rd;

    assign full    = (s_q.cnt == CW'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem_q[s_q.rd];

    always_comb begin
        s_d = s_q;
        if (do_wr) s_d.wr = (s_q.wr == LAST) ? '0 : s_q.wr + 1'b1;
        if (do_rd) s_d.rd = (s_q.rd == LAST) ? '0 : s_q.rd + 1'b1;
        case ({do_wr, do_rd})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[s_q.wr] <= wr_data;
    end

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/mw_engine.sv
module mw_engine
    import mw_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_avail,
    input  logic [CMD_BITS-1:0]  cmd_data,
    output logic                 cmd_pop,
    input  logic [LEN_W-1:0]     resp_len,
    input  logic                 sdi,
    input  logic                 rx_full,
    output logic                 rx_push,
    output logic [RESP_MAX-1:0]  rx_word,
    output logic                 ovr,
    output logic                 sclk,
    output logic                 fs_n,
    output logic                 sdo,
    output logic                 sdo_oe
);
    localparam int CW = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
    localparam logic [CW-1:0] HALF_END = CW'(HALF_DIV - 1);
    localparam logic [CW-1:0] GAP_END  = CW'(2 * HALF_DIV - 1);
    localparam logic [LEN_W-1:0] FIRST_RESP = LEN_W'(CMD_BITS + TURN_BITS);

    typedef struct packed {
        mw_phase_e             phase;
        logic [CW-1:0]         cnt;
        logic                  half;
        logic [LEN_W-1:0]      bitn;
        logic [LEN_W-1:0]      last;
        logic [CMD_BITS-1:0]   cmd;
        logic [RESP_MAX-1:0]   rsh;
        logic                  sclk;
        logic                  fs_n;
        logic                  push;
        logic                  ovr;
    } eng_st_t;

    eng_st_t s_q, s_d;
    logic [LEN_W-1:0] eff_len;

    always_comb begin
        if (resp_len < LEN_W'(RESP_MIN))      eff_len = LEN_W'(RESP_MIN);
        else if (resp_len > LEN_W'(RESP_MAX)) eff_len = LEN_W'(RESP_MAX);
        else                                  eff_len = resp_len;
    end

    always_comb begin
        s_d      = s_q;
        s_d.push = 1'b0;
        cmd_pop  = 1'b0;
        if (s_q.push && rx_full) s_d.ovr = 1'b1;
        case (s_q.phase)
            PH_IDLE: begin
                if (cmd_avail) begin
                    cmd_pop   = 1'b1;
                    s_d.phase = PH_FRAME;
                    s_d.cmd   = cmd_data;
                    s_d.rsh   = '0;
                    s_d.bitn  = '0;
                    s_d.last  = LEN_W'(CMD_BITS + TURN_BITS) + eff_len - 1'b1;
                    s_d.cnt   = '0;
                    s_d.half  = 1'b0;
                    s_d.sclk  = 1'b0;
                    s_d.fs_n  = 1'b0;
                end
            end
            PH_FRAME: begin
                if (s_q.cnt == HALF_END) begin
                    s_d.cnt = '0;
                    if (!s_q.half) begin
                        s_d.half = 1'b1;
                        s_d.sclk = 1'b1;
                        if (s_q.bitn >= FIRST_RESP)
                            s_d.rsh = {s_q.rsh[RESP_MAX-2:0], sdi};
                    end else begin
                        s_d.half = 1'b0;
                        s_d.sclk = 1'b0;
                        if (s_q.bitn == s_q.last) begin
                            s_d.fs_n  = 1'b1;
                            s_d.phase = PH_GAP;
                            s_d.push  = 1'b1;
                        end else begin
                            s_d.bitn = s_q.bitn + 1'b1;
                            s_d.cmd  = {s_q.cmd[CMD_BITS-2:0], 1'b0};
                        end
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_GAP: begin
                if (s_q.cnt == GAP_END) begin
                    s_d.cnt   = '0;
                    s_d.phase = PH_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.fs_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk    = s_q.sclk;
    assign fs_n    = s_q.fs_n;
    assign sdo     = s_q.cmd[CMD_BITS-1];
    assign sdo_oe  = (s_q.phase == PH_FRAME) && (s_q.bitn < LEN_W'(CMD_BITS));
    assign rx_push = s_q.push;
    assign rx_word = s_q.rsh;
    assign ovr     = s_q.ovr;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_n |-> (!sclk && !sdo_oe));
    // R3
    cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && sdo_oe) |-> $stable(sdo));
    // R6
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_FRAME) |-> (s_q.bitn <= s_q.last && s_q.last >= LEN_W'(12)
                                     && s_q.last <= LEN_W'(24)));
    // R8
    push_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $rose(fs_n));
    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> ovr);
endmodule

// File: rtl/mw_master.sv
module mw_master
    import mw_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int HALF_DIV = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_valid,
    input  logic [CMD_BITS-1:0] tx_data,
    output logic                tx_ready,
    input  logic [LEN_W-1:0]    resp_len,
    output logic                rx_valid,
    output logic [RESP_MAX-1:0] rx_data,
    input  logic                rx_ready,
    output logic                ovr,
    output logic                sclk,
    output logic                fs_n,
    output logic                sdo,
    output logic                sdo_oe,
    input  logic                sdi
);
    logic                tx_full, tx_empty, cmd_pop;
    logic [CMD_BITS-1:0] cmd_data;
    logic                rx_full, rx_empty, rx_push;
    logic [RESP_MAX-1:0] rx_word;

    assign tx_ready = !tx_full;
    assign rx_valid = !rx_empty;

    mw_fifo #(.W(CMD_BITS), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tx_valid), .wr_data(tx_data),
        .rd_en(cmd_pop), .rd_data(cmd_data),
        .full(tx_full), .empty(tx_empty)
    );

    mw_engine #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .cmd_avail(!tx_empty), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
        .resp_len(resp_len), .sdi(sdi), .rx_full(rx_full),
        .rx_push(rx_push), .rx_word(rx_word), .ovr(ovr),
        .sclk(sclk), .fs_n(fs_n), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    mw_fifo #(.W(RESP_MAX), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rx_push), .wr_data(rx_word),
        .rd_en(rx_ready), .rd_data(rx_data),
        .full(rx_full), .empty(rx_empty)
    );
endmodule

// File: tb/tb_mw_master.sv
module tb_mw_master;
    localparam int HALF = 2;

    logic clk = 0, rst_n = 0;
    logic tx_valid = 0, rx_ready = 0, sdi = 1;
    logic [7:0]  tx_data = 0;
    logic [4:0]  resp_len = 5'd8;
    logic tx_ready, rx_valid, ovr, sclk, fs_n, sdo, sdo_oe;
    logic [15:0] rx_data;

    int n_chk = 0, n_fail = 0;
    int edge_cnt = 0, hi_run = 0, last_gap = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mw_master #(.TX_DEPTH(4), .RX_DEPTH(4), .HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .resp_len(resp_len), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .ovr(ovr), .sclk(sclk),
        .fs_n(fs_n), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
    );

    always @(posedge sclk) if (!fs_n) edge_cnt <= edge_cnt + 1;

    always @(posedge clk) begin
        if (fs_n) hi_run <= hi_run + 1;
        else begin
            if (hi_run != 0) last_gap <= hi_run;
            hi_run <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_cmd(input logic [7:0] c);
        @(negedge clk); tx_valid = 1; tx_data = c;
        @(negedge clk); tx_valid = 0;
    endtask

    task automatic serve(input int L, input logic [15:0] resp,
                         output logic [7:0] got, output bit oe_err, output int edges);
        int e0;
        got = 0; oe_err = 0; sdi = 1;
        wait (fs_n == 0);
        e0 = edge_cnt;
        for (int i = 0; i < 8; i++) begin
            @(posedge sclk);
            if (!sdo_oe) oe_err = 1;
            got = {got[6:0], sdo};
        end
        @(posedge sclk);
        if (sdo_oe) oe_err = 1;
        for (int j = L - 1; j >= 0; j--) begin
            @(negedge sclk); sdi = resp[j];
            @(posedge sclk);
            if (sdo_oe) oe_err = 1;
        end
        wait (fs_n == 1);
        edges = edge_cnt - e0;
        sdi = 1;
    endtask

    task automatic pop_rx(output logic [15:0] d, output bit v);
        @(negedge clk); v = rx_valid; d = rx_data; rx_ready = 1;
        @(negedge clk); rx_ready = 0;
    endtask

    function automatic logic [15:0] masked(input logic [15:0] r, input int L);
        return (L >= 16) ? r : (r & 16'((32'd1 << L) - 1));
    endfunction

    task automatic one_frame(input logic [7:0] c, input logic [4:0] cfg, input int L,
                             input logic [15:0] resp);
        logic [7:0] got; bit oe_err; int edges; logic [15:0] d; bit v;
        resp_len = cfg;
        push_cmd(c);
        serve(L, resp, got, oe_err, edges);
        chk(got == c, "R3 command bits", got, c);
        chk(!oe_err, "R4/R5 sdo_oe outside command", oe_err, 0);
        chk(edges == 9 + L, "R2/R6 edges per frame", edges, 9 + L);
        repeat (3) @(negedge clk);
        pop_rx(d, v);
        chk(v, "R8 response available", v, 1);
        chk(d == masked(resp, L), "R5 response word", d, masked(resp, L));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(fs_n == 1 && sclk == 0 && sdo_oe == 0, "R1 idle lines",
            {fs_n, sclk, sdo_oe}, 3'b100);
        chk(!rx_valid && !ovr && tx_ready, "R1 flags",
            {rx_valid, ovr, tx_ready}, 3'b001);
    endtask

    task automatic t_lengths;
        one_frame(8'hA5, 5'd8,  8,  16'h00C3);
        one_frame(8'h3C, 5'd4,  4,  16'hFFFA);
        one_frame(8'h81, 5'd16, 16, 16'hBEEF);
    endtask

    task automatic t_clamp;
        one_frame(8'h12, 5'd2,  4,  16'h0009);
        one_frame(8'h34, 5'd20, 16, 16'h5A5A);
        one_frame(8'h56, 5'd0,  4,  16'h0006);
    endtask

    task automatic t_latch;
        logic [7:0] got; bit oe_err; int edges; logic [15:0] d; bit v;
        resp_len = 5'd5;
        push_cmd(8'hC7);
        wait (fs_n == 0);
        @(negedge clk); resp_len = 5'd16;
        serve(5, 16'h0015, got, oe_err, edges);
        chk(edges == 14, "R6 length latched at frame start", edges, 14);
        repeat (3) @(negedge clk);
        pop_rx(d, v);
        chk(v && d == 16'h0015, "R6 latched response", d, 16'h0015);
    endtask

    task automatic t_b2b;
        logic [7:0] g1, g2; bit e1, e2; int n1, n2; logic [15:0] d; bit v;
        resp_len = 5'd4;
        push_cmd(8'hF0);
        push_cmd(8'h0F);
        serve(4, 16'h000A, g1, e1, n1);
        serve(4, 16'h0005, g2, e2, n2);
        chk(last_gap >= 2 * HALF, "R7 select-high gap", last_gap, 2 * HALF);
        chk(g1 == 8'hF0 && g2 == 8'h0F, "R3 back-to-back commands", {g1, g2}, 16'hF00F);
        repeat (3) @(negedge clk);
        pop_rx(d, v);
        chk(v && d == 16'h000A, "R8 order first", d, 16'h000A);
        pop_rx(d, v);
        chk(v && d == 16'h0005, "R8 order second", d, 16'h0005);
    endtask

    task automatic t_overrun;
        logic [7:0] got; bit oe_err; int edges; logic [15:0] d; bit v;
        resp_len = 5'd8;
        for (int k = 0; k < 5; k++) begin
            push_cmd(8'(k));
            serve(8, 16'(8'h10 + k), got, oe_err, edges);
            repeat (3) @(negedge clk);
            if (k == 3) chk(ovr == 0, "R9 no overrun at exactly full", ovr, 0);
        end
        chk(ovr == 1, "R9 overrun flag", ovr, 1);
        for (int k = 0; k < 4; k++) begin
            pop_rx(d, v);
            chk(v && d == 16'(8'h10 + k), "R9 queued words kept", d, 8'h10 + k);
        end
        @(negedge clk);
        chk(!rx_valid, "R9 fifth word dropped", rx_valid, 0);
        chk(ovr == 1, "R9 overrun sticky", ovr, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_lengths();
        t_clamp();
        t_latch();
        t_b2b();
        t_overrun();
        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule